// File: doc/BRIEF.md
# Sector Group Lock and Identifier Unit

This block guards a byte-wide flash array against unwanted writes and answers identification reads. The array is split into fixed-size sectors, and neighbouring sectors are gathered into lock groups of four. Each group has one lock bit. A sideband port sets or clears these bits, and every bit is clear after reset. The command controller asks the block whether a single program address may be written. For a multi-sector erase it passes a one-hot-per-sector request mask, and the block returns the subset that may really be erased.

A level input shows that a high voltage is present on the reset pin. While it is high, every lock is lifted without changing the stored bits. When it drops, the earlier protection is back at once. While the command controller holds the identification mode flag, reads return a manufacturer code, a device code, or the lock state of the group named by the upper address bits, all taken from three low address bits.

Top module: `sector_lock_unit`

## Requirements
- R1: After reset every group is unlocked: `chk_allow` is 1 for any address, `erase_ok` equals `erase_sel`, and every status read returns 00h.
- R2: The group of an address is `addr[ADDR_W-1:SECT_W+2]` (bits 21:18 by default), so four adjacent sectors share one group. A cycle with `lock_we` high stores `lock_val` into group `lock_grp`, and the new value is visible from the next cycle on.
- R3: With `hv_unlock` low, `chk_allow` is 0 when the group holding `chk_addr` is locked and 1 otherwise.
- R4: With `hv_unlock` low, bit s of `erase_ok` is `erase_sel[s]` AND NOT the lock of group s/4, so only sectors in unlocked groups are erased.
- R5: While `hv_unlock` is high, `chk_allow` is 1 and `erase_ok` equals `erase_sel`, and the stored lock bits are kept. After it drops, previously locked groups reject again.
- R6: An identification read with A6=0, A1=0, A0=0 returns the manufacturer code 01h.
- R7: An identification read with A6=0, A1=0, A0=1 returns the device code 41h.
- R8: An identification read with A6=0, A1=1, A0=0 returns 01h if the group in the upper address bits is locked and 00h if not. It reports the stored bit even while `hv_unlock` is high.
- R9: Identification reads with A6=1 or with A1=A0=1 return 00h. Address bits other than A6, A1, A0 and the group bits have no effect on the result.
- R10: Read data and `rd_valid` appear one cycle after `rd_en`. If `id_mode` is low, `rd_valid` stays 0 and `rd_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all locks |
| id_mode | input | 1 | Identification mode flag from the command controller |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 8 | Identification or status byte |
| chk_addr | input | ADDR_W | Program target address to check |
| chk_allow | output | 1 | 1 if a program at `chk_addr` is allowed |
| erase_sel | input | 2^(ADDR_W-SECT_W) | Requested erase sectors, one bit per sector |
| erase_ok | output | 2^(ADDR_W-SECT_W) | Sectors that may actually be erased |
| lock_we | input | 1 | Lock bit write strobe |
| lock_grp | input | ADDR_W-SECT_W-2 | Group index to write |
| lock_val | input | 1 | Value written: 1 locks, 0 unlocks |
| hv_unlock | input | 1 | High voltage on reset pin: temporary unlock |

## Verification
Lock checks are tried with no groups locked, with a single locked group probed at its first and last sector and at the sectors just outside it, and with several groups locked at once. This tells a correct group decode apart from an off-by-one sector-to-group mapping. Erase masks with all sectors requested and with sparse requests show that protection removes only sectors of locked groups and never adds sectors. Identification reads walk all eight A6/A1/A0 combinations with unrelated address bits toggled, both in and out of identification mode. The temporary-unlock level is raised and dropped around locked groups to show that it overrides checks but leaves the stored bits intact.

// File: rtl/sector_lock_unit.sv
module sector_lock_unit #(
  parameter int ADDR_W = 22,
  parameter int SECT_W = 16,
  parameter int GRP_LOG = 2,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h41
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               id_mode,
  input  logic                               rd_en,
  input  logic [ADDR_W-1:0]                  rd_addr,
  output logic                               rd_valid,
  output logic [7:0]                         rd_data,
  input  logic [ADDR_W-1:0]                  chk_addr,
  output logic                               chk_allow,
  input  logic [(1<<(ADDR_W-SECT_W))-1:0]    erase_sel,
  output logic [(1<<(ADDR_W-SECT_W))-1:0]    erase_ok,
  input  logic                               lock_we,
  input  logic [ADDR_W-SECT_W-GRP_LOG-1:0]   lock_grp,
  input  logic                               lock_val,
  input  logic                               hv_unlock
);
  localparam int SIDX_W = ADDR_W - SECT_W;
  localparam int NSECT  = 1 << SIDX_W;
  localparam int GIDX_W = SIDX_W - GRP_LOG;
  localparam int NGRP   = 1 << GIDX_W;

  logic [NGRP-1:0] lock_q;
  logic [GIDX_W-1:0] chk_grp, rd_grp;
  logic [2:0] sel;
  logic [7:0] code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_q <= '0;
    else if (lock_we) lock_q[lock_grp] <= lock_val;

  assign chk_grp   = chk_addr[ADDR_W-1 -: GIDX_W];
  assign chk_allow = hv_unlock | ~lock_q[chk_grp];

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign erase_ok[s] = erase_sel[s] & (hv_unlock | ~lock_q[s >> GRP_LOG]);
  end

  assign rd_grp = rd_addr[ADDR_W-1 -: GIDX_W];
  assign sel    = {rd_addr[6], rd_addr[1], rd_addr[0]};

  always_comb
    case (sel)
      3'b000:  code = MFR_CODE;
      3'b001:  code = DEV_CODE;
      3'b010:  code = {7'd0, lock_q[rd_grp]};
      default: code = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_en & id_mode;
      rd_data  <= (rd_en & id_mode) ? code : 8'h00;
    end

  logic unused_ok;
  assign unused_ok = ^{rd_addr[ADDR_W-GIDX_W-1:7], rd_addr[5:2], chk_addr[ADDR_W-GIDX_W-1:0]};
endmodule

module sector_lock_unit_chk #(
  parameter int ADDR_W = 22,
  parameter int SECT_W = 16,
  parameter int GRP_LOG = 2,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h41
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               id_mode,
  input logic                               rd_en,
  input logic [ADDR_W-1:0]                  rd_addr,
  input logic                               rd_valid,
  input logic [7:0]                         rd_data,
  input logic                               chk_allow,
  input logic [(1<<(ADDR_W-SECT_W))-1:0]    erase_sel,
  input logic [(1<<(ADDR_W-SECT_W))-1:0]    erase_ok,
  input logic                               hv_unlock
);
  p_rd_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && id_mode) |=> rd_valid);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && id_mode) |=> (!rd_valid && rd_data == 8'h00));
  p_mfr_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && id_mode && !rd_addr[6] && !rd_addr[1] && !rd_addr[0]) |=> rd_data == MFR_CODE);
  p_dev_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && id_mode && !rd_addr[6] && !rd_addr[1] && rd_addr[0]) |=> rd_data == DEV_CODE);
  p_status_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && id_mode && !rd_addr[6] && rd_addr[1] && !rd_addr[0]) |=> rd_data[7:1] == 7'd0);
  p_erase_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_ok & ~erase_sel) == '0);
  p_hv_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hv_unlock |-> chk_allow);
  p_hv_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hv_unlock |-> erase_ok == erase_sel);
endmodule

bind sector_lock_unit sector_lock_unit_chk #(
  .ADDR_W(ADDR_W), .SECT_W(SECT_W), .GRP_LOG(GRP_LOG),
  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .id_mode(id_mode), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_data(rd_data), .chk_allow(chk_allow),
  .erase_sel(erase_sel), .erase_ok(erase_ok), .hv_unlock(hv_unlock)
);

// File: tb/sector_lock_unit_tb_top.sv
module sector_lock_unit_tb_top;
  localparam int AW = 22;
  localparam int NS = 64;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n, id_mode, rd_en, rd_valid, chk_allow, lock_we, lock_val, hv_unlock;
  logic [AW-1:0] rd_addr, chk_addr;
  logic [7:0] rd_data;
  logic [NS-1:0] erase_sel, erase_ok;
  logic [GW-1:0] lock_grp;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit [15:0] model = '0;

  always #5 clk = ~clk;

  sector_lock_unit dut_i (
    .clk(clk), .rst_n(rst_n), .id_mode(id_mode), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .chk_addr(chk_addr), .chk_allow(chk_allow),
    .erase_sel(erase_sel), .erase_ok(erase_ok), .lock_we(lock_we), .lock_grp(lock_grp),
    .lock_val(lock_val), .hv_unlock(hv_unlock)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sect_addr(int sect, logic [15:0] off);
    return {sect[5:0], off};
  endfunction

  function automatic logic [NS-1:0] exp_erase(logic [NS-1:0] sel, bit hv);
    logic [NS-1:0] r;
    for (int s = 0; s < NS; s++) r[s] = sel[s] & (hv | !model[s/4]);
    return r;
  endfunction

  task automatic set_lock(int g, bit v);
    @(negedge clk);
    lock_we = 1'b1; lock_grp = g[3:0]; lock_val = v;
    @(negedge clk);
    lock_we = 1'b0;
    model[g] = v;
  endtask

  task automatic do_read(logic [AW-1:0] a, bit mode, output logic [7:0] d, output logic v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; id_mode = mode;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic v;
    check("R1 rd_valid after reset", rd_valid, 0);
    for (int g = 0; g < 16; g++) begin
      chk_addr = sect_addr(g*4+1, 16'h1234); #1;
      check("R1 chk_allow unlocked", chk_allow, 1);
    end
    erase_sel = '1; #1;
    check("R1 erase_ok all", erase_ok, {NS{1'b1}});
    do_read({4'd9, 11'd0, 7'b0000010}, 1'b1, d, v);
    check("R1 status read 00h", d, 8'h00);
  endtask

  task automatic t_group_decode;
    set_lock(5, 1'b1);
    chk_addr = sect_addr(20, 16'h0000); #1; check("R2 R3 first sector of group 5", chk_allow, 0);
    chk_addr = sect_addr(23, 16'hFFFF); #1; check("R2 R3 last sector of group 5", chk_allow, 0);
    chk_addr = sect_addr(19, 16'hFFFF); #1; check("R2 R3 sector below group 5", chk_allow, 1);
    chk_addr = sect_addr(24, 16'h0000); #1; check("R2 R3 sector above group 5", chk_allow, 1);
    set_lock(0, 1'b1);
    set_lock(15, 1'b1);
    chk_addr = sect_addr(0, 16'h0000); #1; check("R3 group 0 locked", chk_allow, 0);
    chk_addr = sect_addr(63, 16'hFFFF); #1; check("R3 group 15 locked", chk_allow, 0);
    set_lock(0, 1'b0);
    chk_addr = sect_addr(2, 16'h0042); #1; check("R2 group 0 cleared", chk_allow, 1);
  endtask

  task automatic t_erase_mask;
    erase_sel = '1; #1;
    check("R4 full erase mask", erase_ok, exp_erase('1, 0));
    erase_sel = 64'hA5A5_0F0F_00F0_3C81; #1;
    check("R4 sparse erase mask", erase_ok, exp_erase(64'hA5A5_0F0F_00F0_3C81, 0));
    erase_sel = '0; #1;
    check("R4 empty erase mask", erase_ok, 64'd0);
  endtask

  task automatic t_hv;
    logic [7:0] d; logic v;
    @(negedge clk); hv_unlock = 1'b1;
    chk_addr = sect_addr(21, 16'h0100); #1; check("R5 hv allows program", chk_allow, 1);
    erase_sel = '1; #1; check("R5 hv allows erase", erase_ok, {NS{1'b1}});
    do_read({4'd5, 11'h7FF, 7'b0111110}, 1'b1, d, v);
    check("R8 status under hv keeps lock", d, 8'h01);
    @(negedge clk); hv_unlock = 1'b0;
    chk_addr = sect_addr(21, 16'h0100); #1; check("R5 lock back after hv", chk_allow, 0);
    check("R5 erase masked after hv", erase_ok, exp_erase('1, 0));
  endtask

  task automatic t_ids;
    logic [7:0] d; logic v;
    do_read({4'd3, 11'h555, 7'b0111100}, 1'b1, d, v);
    check("R6 manufacturer code", d, 8'h01); check("R10 valid", v, 1);
    do_read({4'd12, 11'h2AA, 7'b0000001}, 1'b1, d, v);
    check("R7 device code", d, 8'h41);
    do_read({4'd15, 11'h000, 7'b0000010}, 1'b1, d, v);
    check("R8 group 15 locked", d, 8'h01);
    do_read({4'd6, 11'h000, 7'b0000010}, 1'b1, d, v);
    check("R8 group 6 unlocked", d, 8'h00);
    for (int c = 3; c < 8; c++) begin
      if (c == 3) continue;
      do_read({4'd5, 11'h3C3, c[2], 4'b1010, c[1], c[0]}, 1'b1, d, v);
      check("R9 unused code", d, 8'h00);
    end
    do_read({4'd5, 11'h000, 7'b0000011}, 1'b1, d, v);
    check("R9 A1A0=11", d, 8'h00);
  endtask

  task automatic t_no_mode;
    logic [7:0] d; logic v;
    do_read({4'd1, 11'h0, 7'b0000001}, 1'b0, d, v);
    check("R10 no valid outside id mode", v, 0);
    check("R10 data zero outside id mode", d, 8'h00);
    @(negedge clk);
    check("R10 valid drops after read", rd_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; id_mode = 0; rd_en = 0; rd_addr = '0; chk_addr = '0;
    erase_sel = '0; lock_we = 0; lock_grp = '0; lock_val = 0; hv_unlock = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_group_decode();
    t_erase_mask();
    t_hv();
    t_ids();
    t_no_mode();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule